// File: doc/BRIEF.md
# I2C Bus Master with Software-Paced Wait States

This block is a single-master I2C controller for a simple register-style host. A start trigger places a start condition on the bus and then clocks out the byte already held in the data register as the address byte: seven address bits, most significant first, then the direction bit, where 0 means write. After that, each byte is clocked and acknowledged, and then the controller parks the clock line low. The host sees a one-cycle interrupt and decides what happens next.

The parking point is programmable. It can fall just after the eighth clock, before the acknowledge slot, or just after the ninth (acknowledge) clock. While sending, writing the next byte into the data register is the only thing that restarts the clock. While receiving, a release strobe restarts it, and so does a write of 0xFF. A stop trigger given during a wait closes the transfer. Both bus lines are modelled as open-drain, through active-high pull-low enables and sampled line inputs. The bit period comes from a divider parameter and the start hold time from a cycle-count parameter.

Top module: `i2cw_master`

## Requirements
- R1: A start trigger while idle drives SDA low with SCL released for exactly START_HOLD clock cycles, then pulls SCL low, and sets `busy`. A start trigger while `busy` is high has no effect on the bus.
- R2: Each byte goes out most significant bit first. The first byte after start is the data register content: address in bits 7..1 and the direction bit in bit 0, 0 meaning write. SDA changes only while SCL is low.
- R3: When the direction bit of the address byte has been sent, `tx_mode` becomes 1 if that bit was 0 and 0 if it was 1.
- R4: With `wait_after9`=1, SCL is held low right after the acknowledge clock. With `wait_after9`=0, it is held low right after the eighth clock, and the acknowledge clock follows the release.
- R5: Entering a wait raises `irq` for exactly one cycle, with SCL held low. `ack_seen` latches the inverse of the SDA level sampled on the ninth clock.
- R6: In transmit mode, a data register write ends the wait and its byte is sent. The release strobe has no effect, and SCL stays low.
- R7: In receive mode, the release strobe or a write of 0xFF ends the wait and leaves SDA free for the eight data bits. The received byte appears on `data_out` during the next wait.
- R8: On the ninth clock of a received byte, SDA is pulled low when `ack_en`=1 and left released when `ack_en`=0.
- R9: A stop trigger during a wait first pulls SDA low with SCL low. It then releases SCL, and later releases SDA while SCL is high. `busy` clears once that stop completes, and afterwards neither line is driven.
- R10: When a stop trigger and a wait-ending event arrive in the same cycle, the stop wins and no further clock pulse is issued.
- R11: Every SCL high phase of a bit lasts HALF_DIV clock cycles, and no SCL low phase is shorter than HALF_DIV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_pulse | input | 1 | Start trigger, one cycle |
| stop_pulse | input | 1 | Stop trigger, one cycle |
| data_wr | input | 1 | Data register write strobe |
| data_in | input | 8 | Byte written to the data register |
| release_pulse | input | 1 | Wait-release strobe (receive only) |
| wait_after9 | input | 1 | 1: wait after the ninth clock, 0: after the eighth |
| ack_en | input | 1 | Drive acknowledge on received bytes |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| data_out | output | 8 | Data register content (received byte in receive waits) |
| irq | output | 1 | One-cycle pulse on wait entry |
| busy | output | 1 | Master owns the bus (start to end of stop) |
| tx_mode | output | 1 | 1 transmit, 0 receive |
| ack_seen | output | 1 | Acknowledge detected on the last ninth clock |

## Verification
Two events can collide in one cycle: a stop trigger and the event that ends a wait. The bench fires the stop trigger together with the release strobe while parked in a receive wait. It then requires the bus monitor to see a stop condition, no extra clock edge, no further byte for the scoreboard, and `busy` low afterwards. A start trigger issued while parked in a wait is checked in the same way, as the second overlap: it must leave SCL low and produce no new start condition.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_LOW,
        PH_HIGH,
        PH_WAIT,
        PH_STOP_LOW,
        PH_STOP_HIGH,
        PH_STOP_FREE
    } i2cw_phase_e;

    typedef struct packed {
        logic busy;
        logic addr_ph;
        logic tx;
        logic ack;
    } i2cw_flags_t;

    localparam logic [3:0] ACK_SLOT  = 4'd8;
    localparam logic [3:0] LAST_DATA = 4'd7;

    function automatic logic phase_pulls_scl(i2cw_phase_e p);
        return (p == PH_LOW) || (p == PH_WAIT) || (p == PH_STOP_LOW);
    endfunction

    function automatic logic phase_timed(i2cw_phase_e p);
        return (p != PH_IDLE) && (p != PH_WAIT);
    endfunction

    function automatic logic phase_waits_high(i2cw_phase_e p);
        return (p == PH_HIGH) || (p == PH_STOP_HIGH);
    endfunction

endpackage

// File: rtl/i2cw_timer.sv
module i2cw_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt;

    assign done = en && (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2cw_shift.sv
module i2cw_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         fill,
    input  logic         shift,
    input  logic         bit_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '1;
        end else if (load) begin
            q <= load_val;
        end else if (fill) begin
            q <= '1;
        end else if (shift) begin
            q <= {q[W-2:0], bit_in};
        end
    end
endmodule

// File: rtl/i2cw_master.sv
module i2cw_master
    import i2cw_pkg::*;
#(
    parameter int HALF_DIV   = 250,
    parameter int START_HOLD = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_pulse,
    input  logic       stop_pulse,
    input  logic       data_wr,
    input  logic [7:0] data_in,
    input  logic       release_pulse,
    input  logic       wait_after9,
    input  logic       ack_en,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic [7:0] data_out,
    output logic       irq,
    output logic       busy,
    output logic       tx_mode,
    output logic       ack_seen
);
    localparam int TMAX = (HALF_DIV > START_HOLD) ? HALF_DIV : START_HOLD;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] HALF_T  = TW'(HALF_DIV);
    localparam logic [TW-1:0] START_T = TW'(START_HOLD);

    i2cw_phase_e ph;
    i2cw_flags_t fl;
    logic [3:0]  bitn;
    logic        sda_hold;
    logic        irq_q;

    logic          t_en, t_clr, t_done;
    logic [TW-1:0] t_lim;
    logic          sending, drv_low, wait_go;
    logic          sh_load, sh_fill, sh_shift;
    logic [7:0]    sh_q;

    // bit-phase timer
    assign t_en  = phase_timed(ph) && (phase_waits_high(ph) ? scl_i : 1'b1);
    assign t_lim = (ph == PH_START) ? START_T : HALF_T;
    assign t_clr = !phase_timed(ph) || t_done;

    i2cw_timer #(.CW(TW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (t_clr),
        .en    (t_en),
        .limit (t_lim),
        .done  (t_done)
    );

    // data register doubles as the shift register
    assign sh_load  = data_wr && ((ph == PH_IDLE) || (ph == PH_WAIT));
    assign sh_fill  = release_pulse && (ph == PH_WAIT) && !fl.tx;
    assign sh_shift = (ph == PH_HIGH) && t_done && (bitn != ACK_SLOT);

    i2cw_shift #(.W(8)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (sh_load),
        .load_val (data_in),
        .fill     (sh_fill),
        .shift    (sh_shift),
        .bit_in   (sda_i),
        .q        (sh_q)
    );

    assign sending = fl.addr_ph || fl.tx;
    assign wait_go = fl.tx ? data_wr : (data_wr || release_pulse);

    always_comb begin
        if (bitn == ACK_SLOT) begin
            drv_low = sending ? 1'b0 : ack_en;
        end else begin
            drv_low = !sh_q[7];
        end
    end

    always_comb begin
        unique case (ph)
            PH_START, PH_STOP_LOW, PH_STOP_HIGH: sda_oe = 1'b1;
            PH_LOW:                              sda_oe = drv_low;
            PH_HIGH, PH_WAIT:                    sda_oe = sda_hold;
            default:                             sda_oe = 1'b0;
        endcase
    end

    assign scl_oe   = phase_pulls_scl(ph);
    assign data_out = sh_q;
    assign irq      = irq_q;
    assign busy     = fl.busy;
    assign tx_mode  = fl.tx;
    assign ack_seen = fl.ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            fl       <= '0;
            bitn     <= '0;
            sda_hold <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            unique case (ph)
                PH_IDLE: begin
                    if (start_pulse) begin
                        ph         <= PH_START;
                        fl.busy    <= 1'b1;
                        fl.addr_ph <= 1'b1;
                        bitn       <= '0;
                    end
                end
                PH_START: begin
                    if (t_done) ph <= PH_LOW;
                end
                PH_LOW: begin
                    sda_hold <= drv_low;
                    if (t_done) ph <= PH_HIGH;
                end
                PH_HIGH: begin
                    if (t_done) begin
                        if (bitn != ACK_SLOT) begin
                            if (bitn == LAST_DATA) begin
                                if (fl.addr_ph) fl.tx <= !sda_i;
                                bitn <= ACK_SLOT;
                                if (!wait_after9) begin
                                    ph    <= PH_WAIT;
                                    irq_q <= 1'b1;
                                end else begin
                                    ph <= PH_LOW;
                                end
                            end else begin
                                bitn <= bitn + 1'b1;
                                ph   <= PH_LOW;
                            end
                        end else begin
                            fl.ack     <= !sda_i;
                            fl.addr_ph <= 1'b0;
                            bitn       <= '0;
                            if (wait_after9) begin
                                ph    <= PH_WAIT;
                                irq_q <= 1'b1;
                            end else begin
                                ph <= PH_LOW;
                            end
                        end
                    end
                end
                PH_WAIT: begin
                    if (stop_pulse) begin
                        ph <= PH_STOP_LOW;
                    end else if (wait_go) begin
                        ph <= PH_LOW;
                    end
                end
                PH_STOP_LOW: begin
                    if (t_done) ph <= PH_STOP_HIGH;
                end
                PH_STOP_HIGH: begin
                    if (t_done) ph <= PH_STOP_FREE;
                end
                default: begin
                    if (t_done) begin
                        ph      <= PH_IDLE;
                        fl.busy <= 1'b0;
                    end
                end
            endcase
        end
    end

    AST_IRQ_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        irq |-> scl_oe) else $error("irq without SCL held");  // R5
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq) else $error("irq longer than one cycle");  // R5
    AST_IDLE_BUS_FREE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!scl_oe && !sda_oe)) else $error("line driven while idle");  // R9
    AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_HIGH && $past(ph) == PH_HIGH) |-> $stable(sda_oe))
        else $error("SDA moved while SCL high");  // R2
    AST_WAIT_HOLDS_SCL: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_WAIT && !stop_pulse && !wait_go) |=> scl_oe)
        else $error("SCL released without cause");  // R6
    AST_STOP_WINS: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_WAIT && stop_pulse) |=> (scl_oe && sda_oe))
        else $error("stop did not take priority");  // R10
endmodule

// File: tb/tb_i2cw_master.sv
module tb_i2cw_master;
    localparam int HALF  = 4;
    localparam int SHOLD = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_pulse = 0, stop_pulse = 0, data_wr = 0, release_pulse = 0;
    logic wait_after9 = 1, ack_en = 1;
    logic [7:0] data_in = 8'h00;
    logic scl_oe, sda_oe, irq, busy, tx_mode, ack_seen;
    logic [7:0] data_out;
    logic scl_line, sda_line, slave_low;

    logic slave_ack = 1'b1;
    logic [7:0] rd1 = 8'hFF, rd2 = 8'hFF;

    always #10 clk = ~clk;

    i2cw_master #(.HALF_DIV(HALF), .START_HOLD(SHOLD)) dut (
        .clk(clk), .rst(rst), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
        .data_wr(data_wr), .data_in(data_in), .release_pulse(release_pulse),
        .wait_after9(wait_after9), .ack_en(ack_en), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .data_out(data_out), .irq(irq),
        .busy(busy), .tx_mode(tx_mode), .ack_seen(ack_seen)
    );

    // bus monitor state
    int mpos = 15, mbyte = 0;
    logic mrw = 1'b0;
    logic [7:0] msh = 8'h00;
    logic pscl = 1'b1, psda = 1'b1;
    int starts = 0, stops = 0, falls = 0;
    int hcnt = 0, lcnt = 0, lo_min = 9999, hi_bad = 0, hi_seen = 0;
    int shcnt = 0, sh_len = 0;
    int sb_checks = 0, sb_fails = 0;
    logic [8:0] sbq[$];

    function automatic logic slave_drive(int pos, int byt, logic rw, logic ack,
                                         logic [7:0] b1, logic [7:0] b2);
        logic [7:0] rb;
        rb = (byt == 1) ? b1 : ((byt == 2) ? b2 : 8'hFF);
        if (pos == 8 && (byt == 0 || !rw)) return ack;
        if (pos < 8 && byt > 0 && rw) return !rb[7-pos];
        return 1'b0;
    endfunction

    assign slave_low = slave_drive(mpos, mbyte, mrw, slave_ack, rd1, rd2);
    assign scl_line  = !scl_oe;
    assign sda_line  = !sda_oe && !slave_low;

    // monitor and scoreboard consumer
    always @(negedge clk) begin
        if (pscl && scl_line && psda && !sda_line) begin
            starts++; mpos = 15; mbyte = 0; mrw = 1'b0; shcnt = 1;
        end else if (pscl && scl_line && !psda && sda_line) begin
            stops++; mpos = 15;
        end else if (scl_line && mpos == 15 && !sda_line) begin
            shcnt++;
        end
        if (pscl && !scl_line) begin
            falls++;
            lcnt = 1;
            if (mpos == 15) begin
                sh_len = shcnt; mpos = 0;
            end else begin
                hi_seen++;
                if (hcnt != HALF) hi_bad++;
                if (mpos < 8) begin
                    msh = {msh[6:0], psda};
                    if (mpos == 7 && mbyte == 0) mrw = psda;
                    mpos++;
                end else begin
                    sb_checks++;
                    if (sbq.size() == 0) begin
                        sb_fails++;
                        $display("FAIL R2/R7 unexpected byte act=%h ack=%0d exp=none", msh, !psda);
                    end else begin
                        logic [8:0] e;
                        e = sbq.pop_front();
                        if ({msh, !psda} != e) begin
                            sb_fails++;
                            $display("FAIL R2/R7/R8 byte+ack act=%h exp=%h", {msh, !psda}, e);
                        end
                    end
                    mpos = 0; mbyte++;
                end
            end
        end else if (!pscl && scl_line) begin
            hcnt = 1;
            if (lcnt < lo_min) lo_min = lcnt;
        end else if (scl_line) begin
            hcnt++;
        end else begin
            lcnt++;
        end
        pscl = scl_line;
        psda = sda_line;
    end

    int checks = 0, fails = 0;
    int cyc = 0;
    bit done = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_item(logic [7:0] b, logic a);
        sbq.push_back({b, a});
    endtask

    task automatic pulse_start();
        @(negedge clk) start_pulse = 1;
        @(negedge clk) start_pulse = 0;
    endtask

    task automatic pulse_release();
        @(negedge clk) release_pulse = 1;
        @(negedge clk) release_pulse = 0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop_pulse = 1;
        @(negedge clk) stop_pulse = 0;
    endtask

    task automatic write_data(logic [7:0] v);
        @(negedge clk) begin data_in = v; data_wr = 1; end
        @(negedge clk) data_wr = 0;
    endtask

    task automatic wait_irq(string req);
        int got;
        got = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (irq) begin got = 1; break; end
        end
        check(got == 1, req, "irq seen", got, 1);
        @(negedge clk);
        check(irq == 0, "R5", "irq one cycle", irq, 0);
        check(scl_oe == 1, "R5", "SCL low in wait", scl_oe, 1);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog act=%0d exp=finish", cyc);
            $display("%0d/%0d checks passed", checks + sb_checks - fails - sb_fails,
                     checks + sb_checks);
            $finish;
        end
    end

    initial begin
        int f0, s0, st0, b0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(busy == 0 && scl_oe == 0 && sda_oe == 0 && irq == 0, "R9",
              "reset idle", {busy, scl_oe, sda_oe, irq}, 0);

        // A: write transfer, wait after 9th clock
        wait_after9 = 1; slave_ack = 1;
        write_data(8'hA4);
        expect_item(8'hA4, 1'b1);
        pulse_start();
        wait_irq("R4");
        check(sh_len == SHOLD, "R1", "start hold cycles", sh_len, SHOLD);
        check(busy == 1, "R1", "busy after start", busy, 1);
        check(mpos == 0, "R4", "wait after ack clock pos", mpos, 0);
        check(tx_mode == 1, "R3", "tx_mode on rw=0", tx_mode, 1);
        check(ack_seen == 1, "R5", "ack latched", ack_seen, 1);
        f0 = falls; st0 = starts;
        pulse_release();
        pulse_start();
        repeat (20) @(negedge clk);
        check(scl_oe == 1 && falls == f0, "R6", "release strobe ignored in tx", falls - f0, 0);
        check(starts == st0, "R1", "start ignored while busy", starts - st0, 0);
        expect_item(8'h3C, 1'b1);
        write_data(8'h3C);
        wait_irq("R6");
        slave_ack = 0;
        expect_item(8'h5A, 1'b0);
        write_data(8'h5A);
        wait_irq("R6");
        check(ack_seen == 0, "R5", "nack latched", ack_seen, 0);
        s0 = stops;
        pulse_stop();
        wait_idle();
        @(negedge clk);
        check(stops == s0 + 1, "R9", "stop seen", stops - s0, 1);
        check(busy == 0 && scl_oe == 0 && sda_oe == 0, "R9", "bus free after stop",
              {busy, scl_oe, sda_oe}, 0);
        check(hi_bad == 0 && hi_seen > 0, "R11", "SCL high length", hi_bad, 0);
        check(lo_min == HALF, "R11", "SCL low minimum", lo_min, HALF);

        // B: read transfer
        slave_ack = 1; ack_en = 1; rd1 = 8'h96; rd2 = 8'h3B;
        write_data(8'hA5);
        expect_item(8'hA5, 1'b1);
        pulse_start();
        wait_irq("R4");
        check(tx_mode == 0, "R3", "tx_mode on rw=1", tx_mode, 0);
        expect_item(8'h96, 1'b1);
        pulse_release();
        wait_irq("R7");
        check(data_out == 8'h96, "R7", "received byte", data_out, 8'h96);
        check(ack_seen == 1, "R8", "ack driven with ack_en", ack_seen, 1);
        ack_en = 0;
        expect_item(8'h3B, 1'b0);
        write_data(8'hFF);
        wait_irq("R7");
        check(data_out == 8'h3B, "R7", "received byte after FF write", data_out, 8'h3B);
        check(ack_seen == 0, "R8", "no ack without ack_en", ack_seen, 0);
        s0 = stops; f0 = falls; b0 = sb_checks;
        @(negedge clk) begin stop_pulse = 1; release_pulse = 1; end
        @(negedge clk) begin stop_pulse = 0; release_pulse = 0; end
        wait_idle();
        @(negedge clk);
        check(stops == s0 + 1, "R10", "stop wins", stops - s0, 1);
        check(falls == f0 && sb_checks == b0, "R10", "no clock after stop", falls - f0, 0);

        // C: write transfer, wait after 8th clock
        wait_after9 = 0; ack_en = 1; slave_ack = 1;
        write_data(8'h40);
        expect_item(8'h40, 1'b1);
        pulse_start();
        wait_irq("R4");
        check(mpos == 8, "R4", "wait before ack clock pos", mpos, 8);
        check(sbq.size() == 1, "R4", "ack not yet clocked", sbq.size(), 1);
        write_data(8'h81);
        wait_irq("R4");
        check(mpos == 8 && msh == 8'h81, "R2", "second byte bits", msh, 8'h81);
        check(ack_seen == 1, "R5", "ack of address", ack_seen, 1);
        slave_ack = 0;
        s0 = stops;
        pulse_stop();
        wait_idle();
        @(negedge clk);
        check(stops == s0 + 1 && busy == 0, "R9", "stop from 8-clock wait", stops - s0, 1);
        check(sbq.size() == 0, "R2", "scoreboard drained", sbq.size(), 0);

        done = 1;
        $display("%0d/%0d checks passed", checks + sb_checks - fails - sb_fails,
                 checks + sb_checks);
        $finish;
    end
endmodule